// File: doc/BRIEF.md
# Row-Column Organized Synchronous Static RAM

This block models a synchronous static RAM whose cells form a square grid of rows and columns. The low address bits pick one row through a two-level decoder: small predecoders feed a final AND gate for each row. The next higher address bits steer the column logic. On a write, a column demultiplexer in each sub-array selects the one cell that takes the new bit. On a read, a column multiplexer in each sub-array picks the bit out of the selected row. Chip select gates both directions, so several of these RAMs can share one data bus inside a larger array.

The parameters choose the organization. With `DATA_W=1, ROW_BITS=8, COL_BITS=8` the block is a 65,536 x 1 device: 256 rows by 256 columns. With `DATA_W=4, ROW_BITS=8, COL_BITS=6` it is a 16,384 x 4 device: 256 rows, each split into four sub-arrays of 64 columns, one sub-array per data bit. The memory cells have no reset.

The output stage is a two-state machine with states PORT_FLOAT and PORT_DRIVE. The state register moves to PORT_DRIVE after any clock edge that samples a selected read (transition READ_SEEN). It moves to PORT_FLOAT after any edge that samples a write or a deselected cycle (transition IDLE_SEEN). In PORT_FLOAT the output enable is low and the data lines are held at zero, which stands in for a high-impedance bus.

Top module: `sram_rc_array`

## Requirements
- R1: The row is `addr[ROW_BITS-1:0]` and the column is `addr[ROW_BITS +: COL_BITS]`. A word written at an address reads back from that address, and writes to addresses that differ only in row bits or only in column bits do not disturb it.
- R2: During a selected access the row decoder raises exactly one row line. While chip select is low it raises none.
- R3: A selected write changes only the addressed column of each sub-array. All other cells of the selected row keep their values.
- R4: A clock edge with `cs=1, we=0` sets `dout_en=1` for the following cycle, with `dout` equal to the stored word.
- R5: A clock edge with `cs=0` leaves the array unchanged, even when `we=1`, and sets `dout_en=0` for the following cycle.
- R6: Whenever `dout_en=0`, every bit of `dout` is 0.
- R7: A clock edge with `cs=1, we=1` sets `dout_en=0` for the following cycle.
- R8: In the 4-bit organization, data bit b is stored in sub-array b, and all four bits are written and read independently at each address.
- R9: After reset, `dout_en=0` and `dout=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every access is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| cs | input | 1 | Chip select; high enables a read or a write |
| we | input | 1 | Direction: 1 writes, 0 reads |
| addr | input | ROW_BITS+COL_BITS | Word address; the low bits give the row, the high bits give the column |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data; zero while not driven |
| dout_en | output | 1 | High when `dout` carries valid read data |

## Verification
Both organizations are instantiated and exercised at the corner addresses: all zeros, all ones, highest row with lowest column, and lowest row with highest column. A mistake that swaps or shortens the row/column split shows up there. Neighbour-cell writes in the same row, and writes in the same column of another row, separate a correct column demultiplexer from one that clobbers the whole row. Deselected writes and deselected reads confirm that chip select gates both the array and the output. A long pseudo-random write-then-read pass, plus four-bit patterns such as 0xA, 0x5, 0xF and 0x0, tells apart faults in individual sub-arrays of the wide organization.

// File: rtl/sram_pkg.sv
package sram_pkg;
    typedef enum logic {
        PORT_FLOAT = 1'b0,
        PORT_DRIVE = 1'b1
    } port_state_e;
endpackage

// File: rtl/sram_row_decoder.sv
module sram_row_decoder #(
    parameter int ROW_BITS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [ROW_BITS-1:0]     row_addr,
    output logic [2**ROW_BITS-1:0]  row_line
);
    localparam int LO_BITS = ROW_BITS / 2;
    localparam int HI_BITS = ROW_BITS - LO_BITS;
    localparam int N_LO    = 2 ** LO_BITS;
    localparam int N_HI    = 2 ** HI_BITS;
    localparam int N_ROWS  = 2 ** ROW_BITS;

    logic [N_LO-1:0] pre_lo;
    logic [N_HI-1:0] pre_hi;

    // First level: each predecoder looks at half of the row address
    genvar gi;
    generate
        for (gi = 0; gi < N_LO; gi++) begin : g_pre_lo
            assign pre_lo[gi] = (row_addr[LO_BITS-1:0] == LO_BITS'(gi));
        end
        for (gi = 0; gi < N_HI; gi++) begin : g_pre_hi
            assign pre_hi[gi] = (row_addr[ROW_BITS-1:LO_BITS] == HI_BITS'(gi));
        end
        // Second level: three-input AND per row line
        for (gi = 0; gi < N_ROWS; gi++) begin : g_final
            assign row_line[gi] = en & pre_lo[gi % N_LO] & pre_hi[gi / N_LO];
        end
    endgenerate

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $onehot(row_line)); // R2
    AST_ROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (row_line == '0)); // R2
endmodule

// File: rtl/sram_col_path.sv
module sram_col_path #(
    parameter int DATA_W   = 1,
    parameter int COL_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_act,
    input  logic [COL_BITS-1:0]           col,
    input  logic [DATA_W-1:0]             din,
    input  logic [DATA_W*(2**COL_BITS)-1:0] row_data,
    output logic [DATA_W-1:0]             rd_bits,
    output logic [DATA_W*(2**COL_BITS)-1:0] wr_mask,
    output logic [DATA_W*(2**COL_BITS)-1:0] wr_data
);
    localparam int N_COLS = 2 ** COL_BITS;
    localparam logic [N_COLS-1:0] ONE_HOT_BASE = N_COLS'(1);

    logic [N_COLS-1:0] col_hot;
    assign col_hot = ONE_HOT_BASE << col;

    // One mux and one demux per data bit; sub-array b holds bit b
    genvar gb;
    generate
        for (gb = 0; gb < DATA_W; gb++) begin : g_sub
            assign rd_bits[gb] = row_data[gb*N_COLS + int'(col)];
            assign wr_mask[gb*N_COLS +: N_COLS] = wr_act ? col_hot : '0;
            assign wr_data[gb*N_COLS +: N_COLS] = {N_COLS{din[gb]}};
        end
    endgenerate

    AST_ONE_CELL_PER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |-> ($countones(wr_mask) == DATA_W)); // R3
    AST_NO_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_act |-> (wr_mask == '0)); // R5
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  logic [DATA_W-1:0] rd_bits,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    port_state_e state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        unique case (state_q)
            PORT_FLOAT: state_d = rd_act ? PORT_DRIVE : PORT_FLOAT;
            PORT_DRIVE: state_d = rd_act ? PORT_DRIVE : PORT_FLOAT;
            default:    state_d = PORT_FLOAT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PORT_FLOAT;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_act) data_q <= rd_bits;
        end
    end

    always_comb begin
        unique case (state_q)
            PORT_DRIVE: begin
                dout_en = 1'b1;
                dout    = data_q;
            end
            default: begin
                dout_en = 1'b0;
                dout    = '0;
            end
        endcase
    end

    AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R6
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> dout_en); // R4
    AST_NONREAD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> !dout_en); // R7
endmodule

// File: rtl/sram_rc_array.sv
module sram_rc_array #(
    parameter int DATA_W   = 1,
    parameter int ROW_BITS = 8,
    parameter int COL_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs,
    input  logic                         we,
    input  logic [ROW_BITS+COL_BITS-1:0] addr,
    input  logic [DATA_W-1:0]            din,
    output logic [DATA_W-1:0]            dout,
    output logic                         dout_en
);
    localparam int N_ROWS = 2 ** ROW_BITS;
    localparam int N_COLS = 2 ** COL_BITS;
    localparam int ROW_W  = DATA_W * N_COLS;

    logic [ROW_W-1:0]   cells [N_ROWS];
    logic [N_ROWS-1:0]  row_line;
    logic [ROW_W-1:0]   row_data;
    logic [ROW_W-1:0]   wr_mask;
    logic [ROW_W-1:0]   wr_data;
    logic [DATA_W-1:0]  rd_bits;
    logic               wr_act;
    logic               rd_act;

    assign wr_act = cs & we;
    assign rd_act = cs & ~we;

    sram_row_decoder #(.ROW_BITS(ROW_BITS)) u_rowdec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cs),
        .row_addr (addr[ROW_BITS-1:0]),
        .row_line (row_line)
    );

    // Selected row drives the shared bit lines (AND-OR of all rows)
    always_comb begin
        row_data = '0;
        for (int r = 0; r < N_ROWS; r++) begin
            row_data = row_data | ({ROW_W{row_line[r]}} & cells[r]);
        end
    end

    sram_col_path #(.DATA_W(DATA_W), .COL_BITS(COL_BITS)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_act   (wr_act),
        .col      (addr[ROW_BITS +: COL_BITS]),
        .din      (din),
        .row_data (row_data),
        .rd_bits  (rd_bits),
        .wr_mask  (wr_mask),
        .wr_data  (wr_data)
    );

    always_ff @(posedge clk) begin
        for (int r = 0; r < N_ROWS; r++) begin
            if (row_line[r] && wr_act) begin
                cells[r] <= (cells[r] & ~wr_mask) | (wr_data & wr_mask);
            end
        end
    end

    sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_act  (rd_act),
        .rd_bits (rd_bits),
        .dout    (dout),
        .dout_en (dout_en)
    );

    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !dout_en); // R5
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we) |=> (!dout_en && dout == '0)); // R7
endmodule

// File: tb/tb_sram_rc_array.sv
module tb_sram_rc_array;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // 64K x 1 organization
    logic        cs_n1 = 0, we_n1 = 0;
    logic [15:0] addr_n1 = '0;
    logic [0:0]  din_n1 = '0;
    logic [0:0]  dout_n1;
    logic        en_n1;
    // 16K x 4 organization
    logic        cs_w4 = 0, we_w4 = 0;
    logic [13:0] addr_w4 = '0;
    logic [3:0]  din_w4 = '0;
    logic [3:0]  dout_w4;
    logic        en_w4;

    sram_rc_array #(.DATA_W(1), .ROW_BITS(8), .COL_BITS(8)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs_n1), .we(we_n1), .addr(addr_n1),
        .din(din_n1), .dout(dout_n1), .dout_en(en_n1));

    sram_rc_array #(.DATA_W(4), .ROW_BITS(8), .COL_BITS(6)) dut_w4 (
        .clk(clk), .rst_n(rst_n), .cs(cs_w4), .we(we_w4), .addr(addr_w4),
        .din(din_w4), .dout(dout_w4), .dout_en(en_w4));

    typedef struct {
        bit        wide;
        bit        en;
        logic [3:0] data;
        int        due;
        string     req;
    } exp_t;

    exp_t       sb[$];
    logic [0:0] model_n1 [int];
    logic [3:0] model_w4 [int];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each result in the cycle it is due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic       got_en;
            logic [3:0] got_d;
            e = sb.pop_front();
            got_en = e.wide ? en_w4 : en_n1;
            got_d  = e.wide ? dout_w4 : {3'b000, dout_n1};
            checks++;
            if (got_en !== e.en || got_d !== e.data) begin
                errors++;
                $display("FAIL %s: got en=%0b data=%h, expected en=%0b data=%h",
                         e.req, got_en, got_d, e.en, e.data);
            end
        end
    end

    // Driver: applies one access and queues its expected outcome
    task automatic op(input bit wide, input bit c, input bit w, input int a,
                      input logic [3:0] d, input string req);
        exp_t e;
        @(negedge clk);
        cs_n1 = 0; we_n1 = 0; cs_w4 = 0; we_w4 = 0;
        if (wide) begin
            cs_w4 = c; we_w4 = w; addr_w4 = a[13:0]; din_w4 = d;
        end else begin
            cs_n1 = c; we_n1 = w; addr_n1 = a[15:0]; din_n1 = d[0:0];
        end
        e.wide = wide;
        e.en   = c && !w;
        e.data = 4'h0;
        e.due  = cyc + 1;
        e.req  = req;
        if (c && w) begin
            if (wide) model_w4[a] = d; else model_n1[a] = d[0:0];
        end
        if (e.en) e.data = wide ? model_w4[a] : {3'b000, model_n1[a]};
        sb.push_back(e);
    endtask

    task automatic idle_drain();
        @(negedge clk);
        cs_n1 = 0; we_n1 = 0; cs_w4 = 0; we_w4 = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        int keys[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state of both organizations
        checks++;
        if (en_n1 !== 1'b0 || dout_n1 !== 1'b0 || en_w4 !== 1'b0 || dout_w4 !== 4'h0) begin
            errors++;
            $display("FAIL R9: got en=%0b/%0b dout=%h/%h, expected 0/0 0/0",
                     en_n1, en_w4, dout_n1, dout_w4);
        end

        // R1: corner addresses of the 64K x 1 device
        op(0, 1, 1, 16'h0000, 4'h1, "R1");
        op(0, 1, 1, 16'hFFFF, 4'h1, "R1");
        op(0, 1, 1, 16'h00FF, 4'h0, "R1");
        op(0, 1, 1, 16'hFF00, 4'h1, "R1");
        op(0, 1, 0, 16'h0000, 4'h0, "R1 R4");
        op(0, 1, 0, 16'hFFFF, 4'h0, "R1 R4");
        op(0, 1, 0, 16'h00FF, 4'h0, "R1 R6");
        op(0, 1, 0, 16'hFF00, 4'h0, "R1 R4");

        // R3: neighbours in the same row, then same column in another row
        op(0, 1, 1, 16'h3412, 4'h1, "R3 R7");
        op(0, 1, 1, 16'h3512, 4'h0, "R3");
        op(0, 1, 1, 16'h3312, 4'h0, "R3");
        op(0, 1, 1, 16'h3413, 4'h0, "R2 R3");
        op(0, 1, 0, 16'h3412, 4'h0, "R3");
        op(0, 1, 0, 16'h3512, 4'h0, "R3");

        // R5: deselected write ignored, deselected read floats
        op(0, 0, 1, 16'h3412, 4'h0, "R5");
        op(0, 0, 0, 16'h3412, 4'h0, "R5 R6");
        op(0, 1, 0, 16'h3412, 4'h0, "R5");

        // R8: four-bit organization patterns and corners
        op(1, 1, 1, 14'h0000, 4'hA, "R8");
        op(1, 1, 1, 14'h3FFF, 4'h5, "R8");
        op(1, 1, 1, 14'h00FF, 4'hF, "R8");
        op(1, 1, 1, 14'h3F00, 4'h0, "R8");
        op(1, 1, 1, 14'h0100, 4'h6, "R8 R3");
        op(1, 1, 0, 14'h0000, 4'h0, "R8 R1");
        op(1, 1, 0, 14'h3FFF, 4'h0, "R8 R1");
        op(1, 1, 0, 14'h00FF, 4'h0, "R8");
        op(1, 1, 0, 14'h3F00, 4'h0, "R8 R6");
        op(1, 1, 0, 14'h0100, 4'h0, "R8 R3");
        op(1, 0, 1, 14'h0000, 4'h3, "R5");
        op(1, 1, 0, 14'h0000, 4'h0, "R5 R8");

        // R1 R8: pseudo-random fill then read-back on both devices
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {16'(lfsr) >> 1} ^ ((lfsr & 1) != 0 ? 16'hB400 : 16'h0000);
            keys.push_back(lfsr);
            op(0, 1, 1, lfsr, {3'b000, lfsr[7] ^ lfsr[12]}, "R1");
            op(1, 1, 1, lfsr & 16'h3FFF, 4'(lfsr >> 3), "R8");
        end
        foreach (keys[k]) begin
            op(0, 1, 0, keys[k], 4'h0, "R1");
            op(1, 1, 0, keys[k] & 16'h3FFF, 4'h0, "R8");
        end

        idle_drain();
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R4: got %0d pending results, expected 0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule